// File: doc/BRIEF.md
# Edge-Interrupt Pin Controller

This block is a register-mapped controller for a row of general-purpose pins, sized by a parameter to 16 or 32 pins. Software reaches it over a plain 32-bit bus with a write strobe and a three-bit word address. Each pin is set up through a four-bit field: one bit for the value it drives, one bit that releases the pin so it becomes an input, and one read-only bit that returns the level seen on the pin. Eight such fields share one control word.

Every input passes through a two-stage synchroniser. A third stage keeps the previous level, and comparing the two gives a rising-edge pulse and a falling-edge pulse. Pins are split into banks of sixteen. Each bank has one enable word and one status word. Rising edges set bits in the lower half of the status word and falling edges set bits in the upper half. Status bits latch whether or not they are enabled, and writing a one to a bit clears it. A single registered interrupt line goes high while any status bit has its enable bit set.

Top module: `edgepin_ctrl`

## Requirements
- R1: After reset every enable and status bit is zero, `irq` is low, every `pin_out` bit is 0 and every `pin_oe` bit is 0. Each control word reads 0x22222222 because the release bit of every pin resets to 1.
- R2: Pin n is controlled by the four-bit field at bit (n mod 8)*4 of the control word at address n/8 (addresses 0 to 3). Bit 0 of the field drives `pin_out[n]`. Bit 1 set to 1 releases the pin, so `pin_oe[n]` = 0. Writes take effect on the next cycle.
- R3: Field bit 2 reads the synchronised level of `pin_in[n]`. That level is visible two cycles after the input changes. Writes to field bits 2 and 3 have no effect, and bit 3 always reads 0.
- R4: The low bank (pins 0 to 15) has its enable word at address 4 and its status word at address 5. The high bank (pins 16 to 31) uses addresses 6 and 7. Enable words read back what was written.
- R5: For bank pin k, status bit k sets on a 0-to-1 change and status bit k+16 sets on a 1-to-0 change. The bit becomes readable three cycles after the input changes. It sets whatever the state of its enable bit.
- R6: Writing a status word clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. A set status bit stays set until it is cleared.
- R7: When an edge sets a status bit in the same cycle that a write clears that bit, the bit ends up set.
- R8: `irq` is the OR over both banks of (status AND enable), registered. It follows the status or enable contents one cycle later and stays low while every enable bit is zero.
- R9: With NUM_PINS = 16, addresses 2, 3, 6 and 7 read zero and ignore writes. The low bank still works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Driven pin values |
| pin_oe | output | NUM_PINS | Pin drive enables, 1 = driven |
| irq | output | 1 | Combined interrupt line |

## Verification
Relative to the falling edge at which an input changes, the results are due as follows:
- the sensed level is due at the second falling edge after that;
- the status bit is due at the third;
- `irq` is due at the fourth.

A register write moves `pin_out`, `pin_oe` and the enable words one edge later. Reads are combinational and are sampled 1 ns after the address is set.

The bench drives all stimulus at falling edges. It advances a cycle model at every rising edge, so each compare looks at exactly the cycle the requirements name. The directed cases check the boundary cycles explicitly: the sensed level before and after it arrives, `irq` one cycle before it rises, and a clear that lands in the same cycle as an edge.

// File: rtl/edgepin_pkg.sv
package edgepin_pkg;
    localparam int BUS_W         = 32;
    localparam int ADDR_W        = 3;
    localparam int FIELD_W       = 4;
    localparam int PINS_PER_WORD = BUS_W / FIELD_W;
    localparam int BANK_PINS     = 16;
    localparam int MAX_BANKS     = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTL0  = 3'd0,
        SEL_CTL1  = 3'd1,
        SEL_CTL2  = 3'd2,
        SEL_CTL3  = 3'd3,
        SEL_EN_LO = 3'd4,
        SEL_ST_LO = 3'd5,
        SEL_EN_HI = 3'd6,
        SEL_ST_HI = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/edgepin_sync.sv
module edgepin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg1_q, stg2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1_q <= '0;
            stg2_q <= '0;
            prev_q <= '0;
        end else begin
            stg1_q <= din;
            stg2_q <= stg1_q;
            prev_q <= stg2_q;
        end
    end

    assign lvl  = stg2_q;
    assign rise = stg2_q & ~prev_q;
    assign fall = ~stg2_q & prev_q;
endmodule

// File: rtl/edgepin_irq_bank.sv
module edgepin_irq_bank
    import edgepin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_st,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [BANK_PINS-1:0] rise,
    input  logic [BANK_PINS-1:0] fall,
    output logic [BUS_W-1:0]     en_q,
    output logic [BUS_W-1:0]     st_q,
    output logic                 pend
);
    logic [BUS_W-1:0] clr_mask;
    logic [BUS_W-1:0] set_mask;

    assign clr_mask = wr_st ? wdata : '0;
    assign set_mask = {fall, rise};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (wr_en) begin
                en_q <= wdata;
            end
            // a fresh edge outranks a clear in the same cycle
            st_q <= (st_q & ~clr_mask) | set_mask;
        end
    end

    assign pend = |(en_q & st_q);
endmodule

// File: rtl/edgepin_ctrl.sv
module edgepin_ctrl
    import edgepin_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NUM_BANK = NUM_PINS / BANK_PINS;

    logic [NUM_PINS-1:0]  lvl, rise, fall;
    logic [NUM_PINS-1:0]  out_q, dis_q;
    logic [BUS_W-1:0]     bank_en [MAX_BANKS];
    logic [BUS_W-1:0]     bank_st [MAX_BANKS];
    logic [MAX_BANKS-1:0] bank_pend;
    logic                 irq_q;

    // observation wires for the bound checker
    logic [BUS_W-1:0] st_b0;
    logic             st_any;
    logic             en_any;

    edgepin_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dis_q <= '1;
        end else if (bus_wr) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bus_addr == ADDR_W'(p / PINS_PER_WORD)) begin
                    out_q[p] <= bus_wdata[(p % PINS_PER_WORD) * FIELD_W];
                    dis_q[p] <= bus_wdata[(p % PINS_PER_WORD) * FIELD_W + 1];
                end
            end
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dis_q;

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        if (b < NUM_BANK) begin : g_live
            edgepin_irq_bank u_bank (
                .clk  (clk),
                .rst_n(rst_n),
                .wr_en(bus_wr && (bus_addr == ADDR_W'(32'(SEL_EN_LO) + 2 * b))),
                .wr_st(bus_wr && (bus_addr == ADDR_W'(32'(SEL_ST_LO) + 2 * b))),
                .wdata(bus_wdata),
                .rise (rise[b*BANK_PINS +: BANK_PINS]),
                .fall (fall[b*BANK_PINS +: BANK_PINS]),
                .en_q (bank_en[b]),
                .st_q (bank_st[b]),
                .pend (bank_pend[b])
            );
        end else begin : g_absent
            assign bank_en[b]   = '0;
            assign bank_st[b]   = '0;
            assign bank_pend[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |bank_pend;
        end
    end

    assign irq = irq_q;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            SEL_EN_LO: bus_rdata = bank_en[0];
            SEL_ST_LO: bus_rdata = bank_st[0];
            SEL_EN_HI: bus_rdata = bank_en[1];
            SEL_ST_HI: bus_rdata = bank_st[1];
            default: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (bus_addr == ADDR_W'(p / PINS_PER_WORD)) begin
                        bus_rdata[(p % PINS_PER_WORD) * FIELD_W +: 3] = {lvl[p], dis_q[p], out_q[p]};
                    end
                end
            end
        endcase
    end

    assign st_b0  = bank_st[0];
    assign st_any = |{bank_st[0], bank_st[1]};
    assign en_any = |{bank_en[0], bank_en[1]};
endmodule

// File: rtl/edgepin_chk.sv
module edgepin_chk
    import edgepin_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [BUS_W-1:0]    st_b0,
    input logic                st_any,
    input logic                en_any
);
    // R1: clean state on the first cycle out of reset
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !st_any && !en_any && (pin_oe == '0)));

    // R2: release bit of pin 0 sets its drive enable one cycle later
    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (pin_oe[0] == !$past(bus_wdata[1])));

    // R6: a set status bit stays set unless a one is written to it
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_b0[0] && !(bus_wr && bus_addr == 3'd5 && bus_wdata[0])) |=> st_b0[0]);

    // R6: same for a falling-edge bit
    a_r6_status_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (st_b0[16] && !(bus_wr && bus_addr == 3'd5 && bus_wdata[16])) |=> st_b0[16]);

    // R8: no enabled bit means no interrupt on the next cycle
    a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !en_any |=> !irq);
endmodule

bind edgepin_ctrl edgepin_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .st_b0    (st_b0),
    .st_any   (st_any),
    .en_any   (en_any)
);

// File: tb/edgepin_ctrl_tb_top.sv
`timescale 1ns/1ps
module edgepin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    logic        s_wr;
    logic [2:0]  s_addr;
    logic [31:0] s_wdata;
    logic [31:0] s_rdata;
    logic [15:0] s_pin_out, s_pin_oe;
    logic        s_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    edgepin_ctrl #(.NUM_PINS(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    edgepin_ctrl #(.NUM_PINS(16)) dut16_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .pin_in(16'h0),
        .pin_out(s_pin_out), .pin_oe(s_pin_oe), .irq(s_irq)
    );

    // cycle model of the requirements
    logic [31:0] m_s1, m_s2, m_prev, m_out, m_dis;
    logic [31:0] m_en [2];
    logic [31:0] m_st [2];
    logic        m_irq;

    always @(posedge clk) begin : model
        logic [31:0] r, f, clr;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dis = '1;
            m_en[0] = 0; m_en[1] = 0; m_st[0] = 0; m_st[1] = 0; m_irq = 0;
        end else begin
            r = m_s2 & ~m_prev;
            f = ~m_s2 & m_prev;
            m_irq = (|(m_st[0] & m_en[0])) || (|(m_st[1] & m_en[1]));
            for (int b = 0; b < 2; b++) begin
                clr = (bus_wr && bus_addr == 3'(5 + 2*b)) ? bus_wdata : 32'h0;
                m_st[b] = (m_st[b] & ~clr) | {f[16*b +: 16], r[16*b +: 16]};
                if (bus_wr && bus_addr == 3'(4 + 2*b)) m_en[b] = bus_wdata;
            end
            if (bus_wr && bus_addr < 3'd4) begin
                for (int p = 0; p < 8; p++) begin
                    m_out[int'(bus_addr)*8 + p] = bus_wdata[p*4];
                    m_dis[int'(bus_addr)*8 + p] = bus_wdata[p*4 + 1];
                end
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] v;
        v = 0;
        case (a)
            3'd4: v = m_en[0];
            3'd5: v = m_st[0];
            3'd6: v = m_en[1];
            3'd7: v = m_st[1];
            default:
                for (int p = 0; p < 8; p++)
                    v[p*4 +: 4] = {1'b0, m_s2[int'(a)*8+p], m_dis[int'(a)*8+p], m_out[int'(a)*8+p]};
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        if (a < 3'd4) return "R2 R3 control";
        if (a == 3'd4 || a == 3'd6) return "R4 enable";
        return "R5 R6 R7 status";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, exp_read(a));
    endtask

    task automatic rd16(input logic [2:0] a, input logic [31:0] exp);
        s_addr = a;
        #1;
        chk("R9 16-pin", s_rdata, exp);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [2:0] a;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; pin_in = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        s_wr = 0; s_addr = 0; s_wdata = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        for (int i = 0; i < 8; i++)
            rd(3'(i), "R1 reset read", (i < 4) ? 32'h2222_2222 : 32'h0);

        // R9: narrow configuration
        s_wr = 1; s_addr = 3'd2; s_wdata = '1;
        @(negedge clk);
        s_addr = 3'd6;
        @(negedge clk);
        s_addr = 3'd4;
        @(negedge clk);
        s_wr = 0;
        rd16(3'd2, 0); rd16(3'd3, 0); rd16(3'd6, 0); rd16(3'd7, 0);
        rd16(3'd4, 32'hFFFF_FFFF);

        // R2, R3: field layout, ignored bits
        bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h0000_0F31;
        @(negedge clk);
        bus_wr = 0;
        chk("R2 pin_out[10:8]", pin_out[10:8], 3'b111);
        chk("R2 pin_oe[10:8]", pin_oe[10:8], 3'b001);
        rd(3'd1, "R3 bits 2,3 ignore writes", 32'h0000_0331);

        // R3, R5, R7: pin 0 rises, a clear lands in the same cycle as the set
        pin_in[0] = 1'b1;
        @(negedge clk);
        rd(3'd0, "R3 level not yet seen", 32'h2222_2222);
        @(negedge clk);
        rd(3'd0, "R3 level seen", 32'h2222_2226);
        rd(3'd5, "R5 not yet set", 32'h0);
        bus_wr = 1; bus_addr = 3'd5; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 0;
        rd(3'd5, "R7 set wins over clear, R5 sets unenabled", 32'h1);
        chk("R8 unenabled no irq", irq, 0);
        // R6: clear it
        bus_wr = 1; bus_addr = 3'd5; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 0;
        rd(3'd5, "R6 cleared", 32'h0);

        // R8: enable falling pin 0, then drop it
        bus_wr = 1; bus_addr = 3'd4; bus_wdata = 32'h0001_0000;
        pin_in[0] = 1'b0;
        @(negedge clk);
        bus_wr = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 irq one cycle after status", irq, 0);
        rd(3'd5, "R5 falling bit", 32'h0001_0000);
        @(negedge clk);
        chk("R8 irq raised", irq, 1);
        bus_wr = 1; bus_addr = 3'd5; bus_wdata = 32'h0001_0000;
        @(negedge clk);
        bus_wr = 0;
        chk("R8 irq lags clear", irq, 1);
        rd(3'd5, "R6 falling bit cleared", 32'h0);
        @(negedge clk);
        chk("R8 irq dropped", irq, 0);

        // random phase against the cycle model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            bus_wr = 0;
            chk("R8 irq", irq, m_irq);
            chk("R2 pin_out", pin_out, m_out);
            chk("R2 pin_oe", pin_oe, ~m_dis);
            a = 3'($urandom % 8);
            bus_addr = a;
            #1;
            chk(tag_of(a), bus_rdata, exp_read(a));
            pin_in = pin_in ^ ($urandom & $urandom & $urandom);
            if ($urandom % 3 == 0) begin
                bus_wr = 1;
                bus_addr = 3'($urandom % 8);
                bus_wdata = $urandom;
            end
        end
        @(negedge clk);
        bus_wr = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule